// File: doc/BRIEF.md
# Move-Triggered Arithmetic Function Unit

This block is a function unit for a datapath whose only instruction is a data move between ports. Transport buses write an operand port and a trigger port and read a result port. The operand port loads a register that keeps its value until it is written again. A write to the trigger port starts an operation. The operation works on the operand register and the trigger value, and the opcode sampled with the trigger write selects it. There is no decoded instruction: the trigger write alone starts execution.

Each operation moves through a fixed pipeline. Valid bits travel beside the data stages and track its progress. The finished value goes into a result register. That register keeps it, for any number of reads, until a newer result arrives. A one-cycle pulse marks each completion. A global lock input freezes every stage, the valid bits and the result register, and the unit ignores bus writes for as long as the lock is high. With the shadow option set, the operand is captured at trigger time, so software may rewrite the operand register while the operation is still in flight.

Top module: `move_fu`

## Requirements
- R1: While `rst_n` is low, and after it rises, `res_o` is 0 and `res_ready_o` is 0 until the first result completes.
- R2: An unlocked operand write loads `opnd_i` into the operand register, and the register keeps that value for later triggers until another unlocked operand write.
- R3: Only an unlocked trigger write starts an operation. Every `res_ready_o` pulse matches exactly one accepted trigger, and results come out in trigger order.
- R4: `opsel_i` is sampled with the trigger write. With A the operand and B the trigger value: 0 gives A+B, 1 gives A-B, 2 gives the low `W` bits of A*B, and 3 gives 0. All results are modulo 2^W.
- R5: If a trigger is sampled at clock edge n and no lock intervenes, `res_o` holds the new result and `res_ready_o` is high right after edge n+LAT-1. `LAT` must be at least 3; the default is 3.
- R6: `res_ready_o` is high for exactly one cycle per completed result.
- R7: Triggers on consecutive unlocked cycles are all accepted and give one result per cycle once the pipeline is full.
- R8: With `SHADOW`=1, an operation uses the operand value in effect at trigger time, including an operand write in the same cycle. Operand writes after the trigger do not change that operation's result.
- R9: While `lock_i` is high, `res_o` keeps its value, `res_ready_o` stays low and no in-flight operation advances. After release, the operations in flight complete in order.
- R10: Trigger writes and operand writes made while `lock_i` is high are ignored.
- R11: `fu_ready_o` is high exactly when `rst_n` is high and `lock_i` is low.
- R12: Between completions, `res_o` stays constant and may be read repeatedly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_i | input | 1 | Global lock; freezes the unit |
| opnd_we_i | input | 1 | Operand port write strobe |
| opnd_i | input | W | Operand port data |
| trig_we_i | input | 1 | Trigger port write strobe; starts an operation |
| trig_i | input | W | Trigger port data |
| opsel_i | input | 2 | Opcode field sampled with the trigger write |
| res_o | output | W | Result register port |
| res_ready_o | output | 1 | One-cycle pulse on each result completion |
| fu_ready_o | output | 1 | Unit accepts moves this cycle |

## Verification
The bench applies single isolated triggers, which pin down the exact latency and the one-cycle width of the completion pulse. It applies bursts of back-to-back triggers across all four opcodes, including a subtraction that wraps and a product that overflows, which separate the opcode decode and check ordering and throughput. An operand rewrite in the cycle after a trigger, followed by a trigger with no operand write, distinguishes capture at trigger time from a live read and from a lost operand. A lock held over an operation in flight, with moves attempted during the lock, shows the frozen result, the suppressed pulse, the dropped writes and the correct resumption.

// File: rtl/move_fu.sv
module move_fu #(
  parameter int W      = 16,
  parameter int LAT    = 3,
  parameter bit SHADOW = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lock_i,
  input  logic         opnd_we_i,
  input  logic [W-1:0] opnd_i,
  input  logic         trig_we_i,
  input  logic [W-1:0] trig_i,
  input  logic [1:0]   opsel_i,
  output logic [W-1:0] res_o,
  output logic         res_ready_o,
  output logic         fu_ready_o
);

  localparam int NDLY = LAT - 3;

  logic         adv;
  logic [W-1:0] opnd_q;
  logic [W-1:0] t1, t2;
  logic [1:0]   o1, o2;
  logic         v1, v2;
  logic [W-1:0] a_src;
  logic [W-1:0] alu;
  logic         fin_v;
  logic [W-1:0] fin_d;
  logic [W-1:0] res_q;
  logic         rdy_q;

  assign adv = ~lock_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opnd_q <= '0;
      v1     <= 1'b0;
      v2     <= 1'b0;
      t1     <= '0;
      t2     <= '0;
      o1     <= '0;
      o2     <= '0;
    end else if (adv) begin
      if (opnd_we_i) opnd_q <= opnd_i;
      v1 <= trig_we_i;
      if (trig_we_i) begin
        t1 <= trig_i;
        o1 <= opsel_i;
      end
      v2 <= v1;
      if (v1) begin
        t2 <= t1;
        o2 <= o1;
      end
    end
  end

  generate
    if (SHADOW) begin : g_shadow
      logic [W-1:0] s1, s2;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          s1 <= '0;
          s2 <= '0;
        end else if (adv) begin
          if (trig_we_i) s1 <= opnd_we_i ? opnd_i : opnd_q;
          if (v1)        s2 <= s1;
        end
      end
      assign a_src = s2;
    end else begin : g_live
      assign a_src = opnd_q;
    end
  endgenerate

  always_comb begin
    case (o2)
      2'd0:    alu = a_src + t2;
      2'd1:    alu = a_src - t2;
      2'd2:    alu = a_src * t2;
      default: alu = '0;
    endcase
  end

  generate
    if (NDLY == 0) begin : g_nodly
      assign fin_v = v2;
      assign fin_d = alu;
    end else begin : g_dly
      logic         dv [NDLY];
      logic [W-1:0] dd [NDLY];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < NDLY; i++) begin
            dv[i] <= 1'b0;
            dd[i] <= '0;
          end
        end else if (adv) begin
          dv[0] <= v2;
          if (v2) dd[0] <= alu;
          for (int i = 1; i < NDLY; i++) begin
            dv[i] <= dv[i-1];
            if (dv[i-1]) dd[i] <= dd[i-1];
          end
        end
      end
      assign fin_v = dv[NDLY-1];
      assign fin_d = dd[NDLY-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q <= '0;
      rdy_q <= 1'b0;
    end else if (adv) begin
      rdy_q <= fin_v;
      if (fin_v) res_q <= fin_d;
    end else begin
      rdy_q <= 1'b0;
    end
  end

  assign res_o       = res_q;
  assign res_ready_o = rdy_q;
  assign fu_ready_o  = rst_n & ~lock_i;

endmodule

// File: rtl/move_fu_chk.sv
module move_fu_chk #(
  parameter int W   = 16,
  parameter int LAT = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         lock_i,
  input logic         trig_we_i,
  input logic [W-1:0] res_o,
  input logic         res_ready_o
);

  logic [15:0] outst;

  always_ff @(posedge clk) begin
    if (!rst_n) outst <= '0;
    else outst <= outst + 16'(trig_we_i && !lock_i) - 16'(res_ready_o);
  end

  p_lock_res_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> $stable(res_o));

  p_lock_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> !res_ready_o);

  p_pulse_has_trigger_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready_o |-> (outst != 16'd0));

  p_inflight_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    outst <= 16'(LAT));

  p_res_moves_on_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_o) |-> res_ready_o);

endmodule

bind move_fu move_fu_chk #(.W(W), .LAT(LAT)) u_move_fu_chk (
  .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .trig_we_i(trig_we_i),
  .res_o(res_o), .res_ready_o(res_ready_o)
);

// File: tb/test_move_fu.sv
module test_move_fu;
  localparam int W   = 16;
  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         lock_i = 1'b0;
  logic         opnd_we_i = 1'b0;
  logic [W-1:0] opnd_i = '0;
  logic         trig_we_i = 1'b0;
  logic [W-1:0] trig_i = '0;
  logic [1:0]   opsel_i = '0;
  logic [W-1:0] res_o;
  logic         res_ready_o;
  logic         fu_ready_o;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] opnd_m = '0;
  logic [W-1:0] last_exp = '0;

  always #4 clk = ~clk;

  move_fu #(.W(W), .LAT(LAT), .SHADOW(1'b1)) i_move_fu (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .opnd_we_i(opnd_we_i),
    .opnd_i(opnd_i), .trig_we_i(trig_we_i), .trig_i(trig_i), .opsel_i(opsel_i),
    .res_o(res_o), .res_ready_o(res_ready_o), .fu_ready_o(fu_ready_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] calc(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    case (op)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return W'(a * b);
      default: return '0;
    endcase
  endfunction

  task automatic step(input bit wo, input logic [W-1:0] o, input bit wt, input logic [W-1:0] t, input logic [1:0] op);
    logic [W-1:0] a;
    opnd_we_i = wo; opnd_i = o; trig_we_i = wt; trig_i = t; opsel_i = op;
    if (!lock_i) begin
      a = wo ? o : opnd_m;
      opnd_m = a;
      if (wt) begin
        exp_q.push_back(calc(op, a, t));
        last_exp = calc(op, a, t);
      end
    end
    @(negedge clk);
    opnd_we_i = 1'b0; trig_we_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && res_ready_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 pulse without trigger", 32'(res_o), 32'hFFFF_FFFF);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(res_o == e, "R4 result value", 32'(res_o), 32'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    logic [W-1:0] snap;
    @(negedge clk);
    idle(2);
    check(res_o == '0, "R1 res during reset", 32'(res_o), 0);
    check(fu_ready_o == 1'b0, "R11 ready low in reset", 32'(fu_ready_o), 0);
    rst_n = 1'b1;
    idle(1);
    check(res_o == '0 && res_ready_o == 1'b0, "R1 state after reset", {res_o, 15'd0, res_ready_o}, 0);
    check(fu_ready_o == 1'b1, "R11 ready when unlocked", 32'(fu_ready_o), 1);

    // R5, R6: isolated trigger latency and pulse width
    step(1'b1, 16'd5, 1'b1, 16'd7, 2'd0);
    for (int j = 1; j <= LAT + 1; j++) begin
      check(res_ready_o == (j == LAT), "R5 R6 pulse timing", 32'(res_ready_o), 32'(j == LAT));
      if (j == LAT) check(res_o == 16'd12, "R5 result at latency", 32'(res_o), 12);
      @(negedge clk);
    end

    // R4, R7: back-to-back burst over all opcodes
    cnt = 0;
    fork
      begin
        step(1'b1, 16'd100, 1'b1, 16'd30, 2'd1);
        step(1'b0, 16'd0, 1'b1, 16'd200, 2'd1);
        step(1'b1, 16'h1234, 1'b1, 16'h0456, 2'd2);
        step(1'b0, 16'd0, 1'b1, 16'd9, 2'd3);
        step(1'b1, 16'hFFFF, 1'b1, 16'd2, 2'd0);
      end
      begin
        repeat (12) begin
          @(negedge clk);
          if (res_ready_o) cnt++;
        end
      end
    join
    check(cnt == 5, "R7 one result per trigger in burst", 32'(cnt), 5);
    check(exp_q.size() == 0, "R7 burst drained", 32'(exp_q.size()), 0);

    // R8: operand rewrite right after trigger; R2: held operand reused
    step(1'b1, 16'd9, 1'b1, 16'd3, 2'd2);
    step(1'b1, 16'd1000, 1'b0, 16'd0, 2'd0);
    idle(LAT);
    check(res_o == 16'd27, "R8 shadow operand used", 32'(res_o), 27);
    step(1'b0, 16'd0, 1'b1, 16'd24, 2'd0);
    idle(LAT);
    check(res_o == 16'd1024, "R2 operand register held", 32'(res_o), 1024);

    // R12: result stays readable
    snap = res_o;
    for (int j = 0; j < 4; j++) begin
      check(res_o == snap && !res_ready_o, "R12 result held while idle", 32'(res_o), 32'(snap));
      @(negedge clk);
    end

    // R9, R10: lock with an operation in flight
    step(1'b1, 16'd50, 1'b1, 16'd8, 2'd1);
    snap = res_o;
    lock_i = 1'b1;
    step(1'b1, 16'd7777, 1'b1, 16'd1, 2'd0);
    for (int j = 0; j < 4; j++) begin
      check(res_o == snap && !res_ready_o, "R9 frozen under lock", 32'(res_o), 32'(snap));
      check(!fu_ready_o, "R11 ready low under lock", 32'(fu_ready_o), 0);
      @(negedge clk);
    end
    lock_i = 1'b0;
    idle(LAT + 2);
    check(res_o == 16'd42, "R9 in-flight op completes after lock", 32'(res_o), 42);
    check(exp_q.size() == 0, "R10 locked trigger ignored", 32'(exp_q.size()), 0);
    step(1'b0, 16'd0, 1'b1, 16'd5, 2'd0);
    idle(LAT + 1);
    check(res_o == 16'd55, "R10 locked operand write ignored", 32'(res_o), 55);
    check(res_o == last_exp, "R3 last result in order", 32'(res_o), 32'(last_exp));

    idle(4);
    check(exp_q.size() == 0, "R3 all results delivered", 32'(exp_q.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule